// File: doc/BRIEF.md
# SPI Target Buffered Host Interface

This block is an SPI target (clock idle low, sample on the rising SCK edge, drive on the falling edge) that moves command and response bytes between an external host and a local processor. Each byte the host shifts in lands in a circular input buffer. The byte shifted back out at the same position comes from one of two sources, chosen by an output-select bit. With the bit clear, a single status byte is repeated. With the bit set, the byte comes from an output buffer entry at the same index as the incoming write. Sticky event flags report buffer progress, a receive-count threshold, chip-select edges and end-of-read. A byte-wide register port gives the processor access to configuration, flags, pointers and both buffers.

SCK, chip select and MOSI pass through two-flop synchronizers into the system clock domain. A link state machine has four states. LS_OFF: unit disabled. LS_IDLE: enabled, not selected. LS_SEL: selected, no clock yet. LS_XFER: selected, at least one SCK rising edge seen. Its transitions are as follows. Any state goes to LS_OFF when the enable bit is clear. LS_OFF goes to LS_IDLE when the enable bit is set. LS_IDLE goes to LS_SEL on a chip-select falling edge. LS_SEL goes to LS_XFER on an SCK rising edge. LS_SEL and LS_XFER both return to LS_IDLE on a chip-select rising edge.

The system clock must be at least eight times the SCK frequency, so that MISO settles within half an SCK period. DEPTH must be a power of two of at least 8.

Top module: `spi_tgt_hostif`

## Requirements
- R1: Bytes are received most-significant bit first from MOSI, sampled on rising SCK. Each byte is stored in the input buffer at the current input pointer, which then advances. The processor reads the input buffer at addresses 0x10+i.
- R2: Chip select falling is taken as offset 0. While the output-select bit (CTRL bit 2) is 0, every byte shifted out on MISO is the status-byte register (offset 4), most-significant bit first, driven after each falling SCK edge.
- R3: While the output-select bit is 1, the byte shifted out at a position is the output buffer entry at the same index the incoming byte is written to. The processor writes the output buffer at addresses 0x20+i.
- R4: The input pointer resets to 0 on each chip-select assertion. When the wrap bit (CTRL bit 1) is 1, the pointer returns to 0 after the byte at DEPTH-1.
- R5: When the wrap bit is 0, the pointer stops at DEPTH after the last location. Later bytes in that select period are discarded, and the byte sent out for them is the output entry at index 0.
- R6: Writing index DEPTH/2-1 sets input-half-full (bit 0) and output-half-empty (bit 2). Writing index DEPTH-1 sets input-full (bit 1) and output-empty (bit 3).
- R7: The level event (bit 4) sets when the count of bytes since chip-select assertion equals the threshold in LVL bits 6:0. It never sets when LVL bit 7 (disable) is 1 or when the threshold is 0.
- R8: Chip-select falling (bit 5) and rising (bit 6) events set even with no SCK activity. End-of-read (bit 7) sets on deselect only if at least one SCK rising edge occurred.
- R9: An event sets its flag in STAT (offset 1) only when its bit in the enable register (offset 2) is 1. The irq output is high whenever any flag is 1.
- R10: Flags are sticky and are cleared by writing 1 to them. A flag that is set in the same cycle as its clear stays 1.
- R11: BUSY (offset 7, bit 0) is 1 while selected. The input pointer reads at offset 5. The output pointer reads at offset 6: it equals the input index while selected and 0 otherwise.
- R12: Clearing the unit enable (CTRL bit 0) zeroes all flags and the pointer. While disabled, SPI activity sets no flags, stores no bytes and drives MISO low.
- R13: After reset all registers, pointers and flags read 0, irq is 0 and MISO is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | SPI clock from host, idles low |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| cpu_we | input | 1 | Register port write strobe |
| cpu_addr | input | PTR_W+2 | Register port address, top two bits select region |
| cpu_wdata | input | 8 | Register port write data |
| cpu_rdata | output | 8 | Register port read data, combinational |
| irq | output | 1 | OR of all event flags |

## Verification
The assertions assume the three SPI inputs change slowly compared with the system clock. They also assume SCK never rises and chip select never rises together with another edge in the same synchronized sample, so that each sampled SCK edge is a distinct step of a byte. The host model in the bench meets this assumption. It holds every SCK level for eight system clocks, changes MOSI only together with a falling SCK, and leaves eight clocks of margin around every chip-select edge.

// File: rtl/spi_tgt_pkg.sv
package spi_tgt_pkg;

    typedef enum logic [1:0] {
        LS_OFF  = 2'd0,
        LS_IDLE = 2'd1,
        LS_SEL  = 2'd2,
        LS_XFER = 2'd3
    } link_state_e;

    localparam int EV_W         = 8;
    localparam int EV_IN_HALF   = 0;
    localparam int EV_IN_FULL   = 1;
    localparam int EV_OUT_HALF  = 2;
    localparam int EV_OUT_EMPTY = 3;
    localparam int EV_LEVEL     = 4;
    localparam int EV_CS_FALL   = 5;
    localparam int EV_CS_RISE   = 6;
    localparam int EV_EOR       = 7;

    localparam logic [2:0] RG_CTRL   = 3'd0;
    localparam logic [2:0] RG_STAT   = 3'd1;
    localparam logic [2:0] RG_EVEN   = 3'd2;
    localparam logic [2:0] RG_LVL    = 3'd3;
    localparam logic [2:0] RG_SBYTE  = 3'd4;
    localparam logic [2:0] RG_INPTR  = 3'd5;
    localparam logic [2:0] RG_OUTPTR = 3'd6;
    localparam logic [2:0] RG_BUSY   = 3'd7;

    localparam logic [1:0] RGN_CTRL = 2'd0;
    localparam logic [1:0] RGN_IN   = 2'd1;
    localparam logic [1:0] RGN_OUT  = 2'd2;

endpackage

// File: rtl/spi_tgt_sync.sv
module spi_tgt_sync #(
    parameter int              WIDTH     = 3,
    parameter int              STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [STAGES-1:0] chain_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= {STAGES{RESET_VAL[g]}};
            end else begin
                chain_q <= {chain_q[STAGES-2:0], async_i[g]};
            end
        end

        assign sync_o[g] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/spi_tgt_link.sv
module spi_tgt_link
    import spi_tgt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       sck_s,
    input  logic       cs_n_s,
    input  logic       mosi_s,
    input  logic [7:0] tx_byte,
    output logic       miso,
    output logic       byte_vld,
    output logic [7:0] byte_data,
    output logic       cs_fell,
    output logic       cs_rose,
    output logic       eor,
    output logic       busy
);

    link_state_e state_q, state_d;
    logic        sck_d, cs_d;
    logic        sck_rise, sck_fall, cs_fall_w, cs_rise_w;
    logic        shift_ok;
    logic [2:0]  bit_cnt;
    logic [7:0]  rx_sh, tx_sh;

    // edge detection on synchronized inputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_d <= 1'b0;
            cs_d  <= 1'b1;
        end else begin
            sck_d <= sck_s;
            cs_d  <= cs_n_s;
        end
    end

    assign sck_rise  = sck_s & ~sck_d;
    assign sck_fall  = ~sck_s & sck_d;
    assign cs_fall_w = cs_d & ~cs_n_s;
    assign cs_rise_w = ~cs_d & cs_n_s;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LS_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LS_OFF: begin
                if (en) state_d = LS_IDLE;
            end
            LS_IDLE: begin
                if (!en)            state_d = LS_OFF;
                else if (cs_fall_w) state_d = LS_SEL;
            end
            LS_SEL: begin
                if (!en)            state_d = LS_OFF;
                else if (cs_rise_w) state_d = LS_IDLE;
                else if (sck_rise)  state_d = LS_XFER;
            end
            LS_XFER: begin
                if (!en)            state_d = LS_OFF;
                else if (cs_rise_w) state_d = LS_IDLE;
            end
        endcase
    end

    // outputs
    always_comb begin
        busy      = (state_q == LS_SEL) || (state_q == LS_XFER);
        cs_fell   = en && (state_q == LS_IDLE) && cs_fall_w;
        cs_rose   = en && busy && cs_rise_w;
        eor       = en && (state_q == LS_XFER) && cs_rise_w;
        shift_ok  = en && busy && !cs_rise_w;
        byte_vld  = shift_ok && sck_rise && (bit_cnt == 3'd7);
        byte_data = {rx_sh[6:0], mosi_s};
        miso      = tx_sh[7];
    end

    // shift datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            rx_sh   <= '0;
            tx_sh   <= '0;
        end else if (!en) begin
            bit_cnt <= '0;
            rx_sh   <= '0;
            tx_sh   <= '0;
        end else if (cs_fell) begin
            bit_cnt <= '0;
            tx_sh   <= tx_byte;
        end else if (shift_ok && sck_rise) begin
            rx_sh   <= byte_data;
            bit_cnt <= bit_cnt + 3'd1;
        end else if (shift_ok && sck_fall) begin
            tx_sh   <= (bit_cnt == 3'd0) ? tx_byte : {tx_sh[6:0], 1'b0};
        end
    end

    // R2: MISO only moves after a sampled falling SCK or a select
    a_r2_miso_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !sck_fall && !cs_fell) |=> $stable(miso));

    // R8: end-of-read never without a chip-select rising event
    a_r8_eor_with_rise: assert property (@(posedge clk) disable iff (!rst_n)
        eor |-> (cs_rose && !cs_fell));

endmodule

// File: rtl/spi_tgt_events.sv
module spi_tgt_events #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] mask_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] stat_o,
    output logic         irq_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_o <= '0;
        end else if (!en) begin
            stat_o <= '0;
        end else begin
            stat_o <= (stat_o & ~clr_i) | (set_i & mask_i);
        end
    end

    assign irq_o = |stat_o;

    // R9: a flag only appears when its enable bit was set
    a_r9_masked_set: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> ((stat_o & ~$past(stat_o) & ~$past(mask_i)) == '0));

    // R10: cleared flags drop unless set in the same cycle
    a_r10_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> ((stat_o & $past(clr_i & ~set_i)) == '0));

endmodule

// File: rtl/spi_tgt_hostif.sv
module spi_tgt_hostif
    import spi_tgt_pkg::*;
#(
    parameter  int DEPTH  = 16,
    parameter  int LVL_W  = 7,
    parameter  int STAGES = 2,
    localparam int PTR_W  = $clog2(DEPTH),
    localparam int ADDR_W = PTR_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sck,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [7:0]        cpu_wdata,
    output logic [7:0]        cpu_rdata,
    output logic              irq
);

    localparam int HALF  = DEPTH / 2;
    localparam int CNT_W = LVL_W + 1;

    logic [2:0] sync_q;
    logic       sck_s, cs_n_s, mosi_s;

    logic       ctrl_en, ctrl_wrap, ctrl_osel;
    logic [7:0] ev_en;
    logic [LVL_W-1:0] lvl_thr;
    logic       lvl_dis;
    logic [7:0] sbyte;
    logic [7:0] in_buf  [DEPTH];
    logic [7:0] out_buf [DEPTH];
    logic [PTR_W:0]   in_ptr;
    logic [CNT_W-1:0] lvl_cnt;

    logic       byte_vld, cs_fell, cs_rose, eor, busy;
    logic [7:0] byte_data, tx_byte;
    logic [PTR_W-1:0] tx_idx;
    logic       wr_now, lvl_hit;
    logic [EV_W-1:0] ev_set, ev_clr, ev_stat;

    logic [1:0]       rgn;
    logic [PTR_W-1:0] off;

    assign rgn = cpu_addr[ADDR_W-1 -: 2];
    assign off = cpu_addr[PTR_W-1:0];

    spi_tgt_sync #(
        .WIDTH    (3),
        .STAGES   (STAGES),
        .RESET_VAL(3'b010)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i({spi_mosi, spi_cs_n, spi_sck}),
        .sync_o (sync_q)
    );

    assign sck_s  = sync_q[0];
    assign cs_n_s = sync_q[1];
    assign mosi_s = sync_q[2];

    // transmit byte: index 0 at select, else current position
    assign tx_idx  = cs_fell ? '0 : in_ptr[PTR_W-1:0];
    assign tx_byte = ctrl_osel ? out_buf[tx_idx] : sbyte;

    spi_tgt_link u_link (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (ctrl_en),
        .sck_s    (sck_s),
        .cs_n_s   (cs_n_s),
        .mosi_s   (mosi_s),
        .tx_byte  (tx_byte),
        .miso     (spi_miso),
        .byte_vld (byte_vld),
        .byte_data(byte_data),
        .cs_fell  (cs_fell),
        .cs_rose  (cs_rose),
        .eor      (eor),
        .busy     (busy)
    );

    assign wr_now  = byte_vld && !in_ptr[PTR_W];
    assign lvl_hit = byte_vld && !lvl_dis && (lvl_thr != '0) &&
                     ((lvl_cnt + 1'b1) == {1'b0, lvl_thr});

    always_comb begin
        ev_set               = '0;
        ev_set[EV_IN_HALF]   = wr_now && (in_ptr[PTR_W-1:0] == PTR_W'(HALF - 1));
        ev_set[EV_OUT_HALF]  = ev_set[EV_IN_HALF];
        ev_set[EV_IN_FULL]   = wr_now && (in_ptr[PTR_W-1:0] == PTR_W'(DEPTH - 1));
        ev_set[EV_OUT_EMPTY] = ev_set[EV_IN_FULL];
        ev_set[EV_LEVEL]     = lvl_hit;
        ev_set[EV_CS_FALL]   = cs_fell;
        ev_set[EV_CS_RISE]   = cs_rose;
        ev_set[EV_EOR]       = eor;
        ev_clr = (cpu_we && rgn == RGN_CTRL && off[2:0] == RG_STAT) ? cpu_wdata : '0;
    end

    spi_tgt_events #(.N(EV_W)) u_events (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (ctrl_en),
        .set_i (ev_set),
        .mask_i(ev_en),
        .clr_i (ev_clr),
        .stat_o(ev_stat),
        .irq_o (irq)
    );

    // configuration registers and output buffer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_en   <= 1'b0;
            ctrl_wrap <= 1'b0;
            ctrl_osel <= 1'b0;
            ev_en     <= '0;
            lvl_thr   <= '0;
            lvl_dis   <= 1'b0;
            sbyte     <= '0;
            for (int i = 0; i < DEPTH; i++) out_buf[i] <= '0;
        end else if (cpu_we) begin
            if (rgn == RGN_CTRL) begin
                unique case (off[2:0])
                    RG_CTRL:  {ctrl_osel, ctrl_wrap, ctrl_en} <= cpu_wdata[2:0];
                    RG_EVEN:  ev_en <= cpu_wdata;
                    RG_LVL: begin
                        lvl_thr <= cpu_wdata[LVL_W-1:0];
                        lvl_dis <= cpu_wdata[7];
                    end
                    RG_SBYTE: sbyte <= cpu_wdata;
                    default: ;
                endcase
            end else if (rgn == RGN_OUT) begin
                out_buf[off] <= cpu_wdata;
            end
        end
    end

    // input pointer and level counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_ptr  <= '0;
            lvl_cnt <= '0;
        end else if (!ctrl_en || cs_fell) begin
            in_ptr  <= '0;
            lvl_cnt <= '0;
        end else if (byte_vld) begin
            if (!lvl_cnt[CNT_W-1] || lvl_cnt != '1) lvl_cnt <= lvl_cnt + 1'b1;
            if (wr_now) begin
                if (in_ptr[PTR_W-1:0] == PTR_W'(DEPTH - 1)) begin
                    in_ptr <= ctrl_wrap ? '0 : (PTR_W+1)'(DEPTH);
                end else begin
                    in_ptr <= in_ptr + 1'b1;
                end
            end
        end
    end

    // input buffer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) in_buf[i] <= '0;
        end else if (wr_now) begin
            in_buf[in_ptr[PTR_W-1:0]] <= byte_data;
        end
    end

    // read mux
    always_comb begin
        cpu_rdata = '0;
        unique case (rgn)
            RGN_CTRL: begin
                unique case (off[2:0])
                    RG_CTRL:   cpu_rdata = {5'b0, ctrl_osel, ctrl_wrap, ctrl_en};
                    RG_STAT:   cpu_rdata = ev_stat;
                    RG_EVEN:   cpu_rdata = ev_en;
                    RG_LVL:    cpu_rdata = {lvl_dis, 7'(lvl_thr)};
                    RG_SBYTE:  cpu_rdata = sbyte;
                    RG_INPTR:  cpu_rdata = 8'(in_ptr);
                    RG_OUTPTR: cpu_rdata = busy ? 8'(in_ptr[PTR_W-1:0]) : 8'd0;
                    RG_BUSY:   cpu_rdata = {7'b0, busy};
                endcase
            end
            RGN_IN:  cpu_rdata = in_buf[off];
            RGN_OUT: cpu_rdata = out_buf[off];
            default: cpu_rdata = '0;
        endcase
    end

    // R4: wrap returns pointer to zero after the last location
    a_r4_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_en && wr_now && ctrl_wrap && in_ptr == (PTR_W+1)'(DEPTH - 1)) |=> (in_ptr == '0));

    // R5: pointer never exceeds DEPTH
    a_r5_ptr_bound: assert property (@(posedge clk) disable iff (!rst_n)
        in_ptr <= (PTR_W+1)'(DEPTH));

    // R5: a stopped pointer stays stopped until the next select
    a_r5_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_en && in_ptr[PTR_W] && !cs_fell) |=> in_ptr[PTR_W]);

    // R12: disabling clears flags and pointer
    a_r12_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_en |=> ((ev_stat == '0) && (in_ptr == '0)));

endmodule

// File: tb/test_spi_tgt_hostif.sv
module test_spi_tgt_hostif;

    localparam int D = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spi_sck = 1'b0;
    logic       spi_cs_n = 1'b1;
    logic       spi_mosi = 1'b0;
    logic       spi_miso;
    logic       cpu_we = 1'b0;
    logic [5:0] cpu_addr = '0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic       irq;

    int n_cmp = 0;
    int n_mis = 0;

    // reference model state
    bit         m_en, m_wrap, m_osel, m_dis;
    logic [7:0] m_even, m_sbyte, m_stat;
    int         m_thr, m_ptr, m_cnt;
    logic [7:0] m_in  [D];
    logic [7:0] m_out [D];
    bit         m_val [D];

    always #4 clk = ~clk;

    spi_tgt_hostif i_spi_tgt_hostif (
        .clk      (clk),
        .rst_n    (rst_n),
        .spi_sck  (spi_sck),
        .spi_cs_n (spi_cs_n),
        .spi_mosi (spi_mosi),
        .spi_miso (spi_miso),
        .cpu_we   (cpu_we),
        .cpu_addr (cpu_addr),
        .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata),
        .irq      (irq)
    );

    task automatic check(input string rq, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_mis++;
            $display("FAIL %s: actual %02h expected %02h", rq, act, exp);
        end
    endtask

    task automatic post(input int b);
        if (m_en) m_stat = m_stat | (m_even & (8'd1 << b));
    endtask

    task automatic cpu_wr(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_we = 1'b0;
        if (a[5:4] == 2'd0) begin
            case (a[2:0])
                3'd0: begin
                    m_en = d[0]; m_wrap = d[1]; m_osel = d[2];
                    if (!m_en) begin m_stat = '0; m_ptr = 0; end
                end
                3'd1: m_stat = m_stat & ~d;
                3'd2: m_even = d;
                3'd3: begin m_thr = int'(d[6:0]); m_dis = d[7]; end
                3'd4: m_sbyte = d;
                default: ;
            endcase
        end else if (a[5:4] == 2'd2) begin
            m_out[a[3:0]] = d;
        end
    endtask

    task automatic cpu_rd(input logic [5:0] a, output logic [7:0] d);
        @(negedge clk);
        cpu_addr = a;
        #1 d = cpu_rdata;
    endtask

    task automatic xfer(input int n, input logic [7:0] seed, input string tg);
        logic [7:0] rd, got, exp_b, tx;
        spi_cs_n = 1'b0;
        if (m_en) begin m_ptr = 0; m_cnt = 0; post(5); end
        repeat (8) @(negedge clk);
        cpu_rd(6'h07, rd); check({tg, " R11 busy"}, rd, m_en ? 8'd1 : 8'd0);
        cpu_rd(6'h06, rd); check({tg, " R11 outptr-sel"}, rd, 8'd0);
        for (int k = 0; k < n; k++) begin
            tx = seed + 8'(k * 29);
            exp_b = !m_en ? 8'd0 : (m_osel ? m_out[m_ptr % D] : m_sbyte);
            got = '0;
            for (int b = 7; b >= 0; b--) begin
                spi_mosi = tx[b];
                repeat (8) @(negedge clk);
                got = {got[6:0], spi_miso};
                spi_sck = 1'b1;
                repeat (8) @(negedge clk);
                spi_sck = 1'b0;
            end
            check({tg, m_osel ? " R3 miso" : " R2 miso"}, got, exp_b);
            if (m_en) begin
                if (m_ptr < D) begin
                    m_in[m_ptr] = tx; m_val[m_ptr] = 1'b1;
                    if (m_ptr == D/2 - 1) begin post(0); post(2); end
                    if (m_ptr == D - 1) begin
                        post(1); post(3);
                        m_ptr = m_wrap ? 0 : D;
                    end else begin
                        m_ptr++;
                    end
                end
                m_cnt++;
                if (!m_dis && m_thr != 0 && m_cnt == m_thr) post(4);
            end
        end
        repeat (8) @(negedge clk);
        spi_cs_n = 1'b1;
        if (m_en) begin post(6); if (n > 0) post(7); end
        repeat (10) @(negedge clk);
    endtask

    task automatic after_check(input string tg);
        logic [7:0] rd;
        cpu_rd(6'h01, rd); check({tg, " R9 stat"}, rd, m_stat);
        check({tg, " R9 irq"}, {7'b0, irq}, {7'b0, m_stat != 0});
        cpu_rd(6'h05, rd); check({tg, " R4 inptr"}, rd, 8'(m_ptr));
        cpu_rd(6'h06, rd); check({tg, " R11 outptr-idle"}, rd, 8'd0);
        cpu_rd(6'h07, rd); check({tg, " R11 idle"}, rd, 8'd0);
        for (int i = 0; i < D; i++) begin
            if (m_val[i]) begin
                cpu_rd(6'(16 + i), rd); check({tg, " R1 inbuf"}, rd, m_in[i]);
            end
        end
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_mis++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] rd;
        m_en = 0; m_wrap = 0; m_osel = 0; m_dis = 0;
        m_even = '0; m_sbyte = '0; m_stat = '0; m_thr = 0; m_ptr = 0; m_cnt = 0;
        for (int i = 0; i < D; i++) begin m_in[i] = '0; m_out[i] = '0; m_val[i] = 0; end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R13 reset state
        cpu_rd(6'h00, rd); check("R13 ctrl", rd, 8'd0);
        cpu_rd(6'h01, rd); check("R13 stat", rd, 8'd0);
        cpu_rd(6'h05, rd); check("R13 inptr", rd, 8'd0);
        cpu_rd(6'h07, rd); check("R13 busy", rd, 8'd0);
        check("R13 irq", {7'b0, irq}, 8'd0);
        check("R13 miso", {7'b0, spi_miso}, 8'd0);

        // status-byte mode with level threshold (R2 R7 R8)
        cpu_wr(6'h02, 8'hFF);
        cpu_wr(6'h03, 8'd3);
        cpu_wr(6'h04, 8'hA5);
        cpu_wr(6'h00, 8'h03);
        xfer(4, 8'h3C, "R7");
        after_check("R8");

        // R10 write-one-to-clear, partial then full
        cpu_wr(6'h01, 8'h20);
        cpu_rd(6'h01, rd); check("R10 partial", rd, m_stat);
        cpu_wr(6'h01, 8'hFF);
        cpu_rd(6'h01, rd); check("R10 all", rd, 8'd0);
        check("R10 irq", {7'b0, irq}, 8'd0);

        // buffer streaming across the midpoint (R3 R6)
        for (int i = 0; i < D; i++) cpu_wr(6'(32 + i), 8'(i * 17 + 3));
        cpu_wr(6'h00, 8'h07);
        xfer(10, 8'h51, "R6");
        after_check("R6");

        // wrap past the end (R4 R6)
        cpu_wr(6'h01, 8'hFF);
        xfer(17, 8'h90, "R4");
        after_check("R4");

        // no wrap: pointer stops, extra bytes dropped (R5)
        cpu_wr(6'h00, 8'h05);
        cpu_wr(6'h01, 8'hFF);
        xfer(18, 8'h07, "R5");
        after_check("R5");

        // only rising-edge event enabled (R9)
        cpu_wr(6'h00, 8'h03);
        cpu_wr(6'h02, 8'h40);
        cpu_wr(6'h01, 8'hFF);
        xfer(3, 8'h22, "R9");
        after_check("R9");

        // level event disabled (R7)
        cpu_wr(6'h02, 8'hFF);
        cpu_wr(6'h03, 8'h82);
        cpu_wr(6'h01, 8'hFF);
        xfer(3, 8'h44, "R7");
        after_check("R7");

        // select without clocks (R8)
        cpu_wr(6'h01, 8'hFF);
        xfer(0, 8'h00, "R8");
        after_check("R8");

        // unit disable (R12)
        cpu_wr(6'h00, 8'h00);
        cpu_rd(6'h01, rd); check("R12 stat", rd, 8'd0);
        cpu_rd(6'h05, rd); check("R12 inptr", rd, 8'd0);
        xfer(2, 8'hEE, "R12");
        after_check("R12");

        summary();
        $finish;
    end

endmodule